// File: doc/BRIEF.md
# Wrapping Burst Read Sequencer

This block is the device side of a synchronous burst-read memory port. The host pulses an advance strobe while the chip is enabled, and the port latches a word address on that clock edge. After a programmable initial latency it presents 32-bit words on every clock. The words come from the aligned group of 2, 4 or 8 words that holds the start address. The order begins at the start offset and wraps around inside the group. An active-low end-of-group flag marks the last word before each wrap.

A small configuration register sets burst enable, group size and latency. Loads of that register or of the protection word are single reads that stay on the bus for as long as the output enable is held, even when bursts are enabled. With bursts disabled, a main-array load is also a single held word. A secured region can be selected at latch time; its words beyond the secured window come back zeroed and flagged as invalid. Bus float is modelled by drive-enable outputs, which are high only while the matching pin would be driven.

Top module: `burst_seq`

## Requirements
- R1: The configuration register is written by `cfg_we`/`cfg_wdata`. Bit 0 is burst enable. Bits 2:1 set the group size: 2'b11 gives 8, 2'b10 gives 4, and 2'b01 or 2'b00 give 2. Bits 5:3 set the latency, where 0 counts as 1. Its reset value is 6'h16 (latency 2, group 8, bursts off). Settings are captured when a read is latched.
- R2: An address is latched on any rising edge where `adv` and `chip_en` are both high. The first word is presented (`dvalid` high) after the L-th rising edge following the latch edge, where L is the latency, and not before.
- R3: A burst of group size N presents the addresses (A & ~(N-1)) | ((A+k) mod N) for k = 0,1,2,..., where A is the latched address.
- R4: `eob_n` is low during the word at k mod N = N-1 and high otherwise. If clocking continues with output enable active, the next word is the latched start address again, and the sequence keeps wrapping.
- R5: `eob_oe` is high exactly while `chip_en` and `out_en` are high and a read is in progress, latency included. While driven, `eob_n` stays high except on the last word of the group.
- R6: A new latch during a burst discards the old address. The new burst restarts its full latency and sequence from the new address, and no word is valid during that latency.
- R7: With `chip_en` low, `dq_oe`, `eob_oe` and `dvalid` are low in the same cycle, and the read ends at the next edge. Raising `chip_en` again without a latch presents nothing.
- R8: With `out_en` low, `dq_oe`, `eob_oe` and `dvalid` are low, but the burst keeps advancing one word per clock. If the last word of the group passes while `out_en` is low, the burst ends.
- R9: An active-low `rst_n` acts at once without a clock: it releases the bus and indicator, ends any read and restores the configuration register to 6'h16.
- R10: A latch with `reg_sel` high reads a register location with no latency: the configuration register (zero-extended) at an even address, or the protection word PROT_WORD (default 32'h000000A5) at an odd one. The word is shown after the latch edge and held unchanged for as long as `out_en` stays high, with `eob_n` high.
- R11: With burst enable at 0, a main-array read presents one word after the latency and holds it unchanged while `out_en` stays high, without asserting `eob_n`.
- R12: Main-array word at address a is {~a[15:0], a[15:0]}. A secured word (`sec_sel` high at latch) at address a below SEC_WORDS (default 64) is {16'h5EC0, a[15:0]} with `data_bad` low. At or above SEC_WORDS it is 0 with `data_bad` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable, active high |
| out_en | input | 1 | Output enable, active high |
| adv | input | 1 | Advance strobe; latches `addr` with `chip_en` |
| addr | input | AW | Word address |
| reg_sel | input | 1 | Latch targets register/protection space |
| sec_sel | input | 1 | Latch targets the secured region |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | LAT_W+3 | Configuration register write value |
| dq | output | DW | Read data, zero when not presented |
| dq_oe | output | 1 | Data bus drive enable |
| dvalid | output | 1 | A word is presented this cycle |
| data_bad | output | 1 | Presented secured word is outside the window |
| eob_n | output | 1 | End-of-group indicator, active low |
| eob_oe | output | 1 | Indicator drive enable |

## Verification
A wrong group mask or offset counter shows up on the second presented word as an address outside the expected wrap order. A wrong end-of-group position shows up within one group as `eob_n` low on the wrong word, or as a next word that is not the start address. A latency counter that is off by one moves the first `dvalid` one cycle early or late, so it is seen on the very first word of each burst. Faults in enable gating or reset are seen in the same cycle as the stimulus, because the drive-enable outputs follow `chip_en`, `out_en` and `rst_n` combinationally.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int LAT_W     = 3,
  parameter int DEF_LAT   = 2,
  parameter int SEC_WORDS = 64,
  parameter logic [31:0] PROT_WORD = 32'h0000_00A5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             out_en,
  input  logic             adv,
  input  logic [AW-1:0]    addr,
  input  logic             reg_sel,
  input  logic             sec_sel,
  input  logic             cfg_we,
  input  logic [LAT_W+2:0] cfg_wdata,
  output logic [DW-1:0]    dq,
  output logic             dq_oe,
  output logic             dvalid,
  output logic             data_bad,
  output logic             eob_n,
  output logic             eob_oe
);
  localparam int CFG_W = LAT_W + 3;
  localparam logic [CFG_W-1:0] CFG_DEF = {LAT_W'(DEF_LAT), 2'b11, 1'b0};

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_BURST, S_HOLD} st_t;

  st_t              st;
  logic [CFG_W-1:0] cfg;
  logic [LAT_W-1:0] cnt;
  logic [AW-1:0]    base_q;
  logic [1:0]       len_q;
  logic [2:0]       idx;
  logic             reg_q, sec_q, burst_q;

  function automatic logic [2:0] grp_mask(input logic [1:0] code);
    case (code)
      2'b11:   return 3'd7;
      2'b10:   return 3'd3;
      default: return 3'd1;
    endcase
  endfunction

  wire             start   = chip_en && adv;
  wire [2:0]       m3      = grp_mask(len_q);
  wire [AW-1:0]    m       = AW'(m3);
  wire [LAT_W-1:0] cfg_lat = cfg[CFG_W-1:3];
  wire [LAT_W-1:0] lat_eff = (cfg_lat == '0) ? LAT_W'(1) : cfg_lat;
  wire [AW-1:0]    cur_addr = (base_q & ~m) | ((base_q + AW'(idx)) & m);
  wire [15:0]      a16     = 16'(cur_addr);
  wire             sec_bad = sec_q && (32'(cur_addr) >= SEC_WORDS);
  wire             presenting = (st == S_BURST) || (st == S_HOLD);
  wire             vis     = chip_en && out_en && presenting;
  wire             last    = (st == S_BURST) && (idx == m3);

  logic [31:0] word;
  always_comb begin
    if (reg_q)        word = base_q[0] ? PROT_WORD : 32'(cfg);
    else if (sec_q)   word = sec_bad ? 32'd0 : {16'h5EC0, a16};
    else              word = {~a16, a16};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cfg     <= CFG_DEF;
      cnt     <= '0;
      base_q  <= '0;
      len_q   <= 2'b00;
      idx     <= 3'd0;
      reg_q   <= 1'b0;
      sec_q   <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      if (cfg_we) cfg <= cfg_wdata;
      if (start) begin
        base_q  <= addr;
        reg_q   <= reg_sel;
        sec_q   <= sec_sel && !reg_sel;
        len_q   <= cfg[2:1];
        burst_q <= cfg[0] && !reg_sel;
        idx     <= 3'd0;
        cnt     <= lat_eff;
        st      <= reg_sel ? S_HOLD : S_WAIT;
      end else if (!chip_en) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_WAIT:
            if (cnt == LAT_W'(1)) st <= burst_q ? S_BURST : S_HOLD;
            else cnt <= cnt - LAT_W'(1);
          S_BURST: begin
            idx <= (idx + 3'd1) & m3;
            if (idx == m3 && !out_en) st <= S_IDLE;
          end
          S_HOLD:
            if (!out_en) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign dq_oe    = vis;
  assign dvalid   = vis;
  assign dq       = vis ? DW'(word) : '0;
  assign data_bad = vis && sec_bad;
  assign eob_oe   = chip_en && out_en && (st != S_IDLE);
  assign eob_n    = !last;

  p_bus_needs_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (!dq_oe && !eob_oe && !dvalid));

  p_ce_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> (!dq_oe && !eob_oe));

  p_eob_on_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eob_oe && !eob_n) |-> dvalid);

  p_wrap_to_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BURST && !eob_n && chip_en && out_en && !adv) |=> (cur_addr == base_q));

  p_linear_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BURST && $past(st) == S_BURST && !$past(start)) |->
      ((((cur_addr - $past(cur_addr)) & m) == AW'(1)) &&
       ((cur_addr & ~m) == ($past(cur_addr) & ~m))));

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && $past(st) == S_HOLD && !$past(start) && !$past(cfg_we) && vis)
      |-> $stable(dq));
endmodule

// File: tb/burst_seq_bench.sv
module burst_seq_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_en = 1'b0, out_en = 1'b0, adv = 1'b0;
  logic [7:0]  addr = '0;
  logic        reg_sel = 1'b0, sec_sel = 1'b0, cfg_we = 1'b0;
  logic [5:0]  cfg_wdata = '0;
  logic [31:0] dq;
  logic        dq_oe, dvalid, data_bad, eob_n, eob_oe;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  burst_seq u_burst_seq (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .out_en(out_en), .adv(adv),
    .addr(addr), .reg_sel(reg_sel), .sec_sel(sec_sel), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .dq(dq), .dq_oe(dq_oe), .dvalid(dvalid),
    .data_bad(data_bad), .eob_n(eob_n), .eob_oe(eob_oe)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wd(input logic [7:0] a, input bit sec);
    return sec ? {16'h5EC0, 8'h00, a} : {~{8'h00, a}, {8'h00, a}};
  endfunction

  task automatic set_cfg(input logic [5:0] v);
    cfg_wdata = v; cfg_we = 1'b1; tick(); cfg_we = 1'b0;
  endtask

  task automatic start_rd(input logic [7:0] a, input bit rs, input bit ss);
    addr = a; reg_sel = rs; sec_sel = ss; adv = 1'b1;
    tick();
    adv = 1'b0; reg_sel = 1'b0; sec_sel = 1'b0;
  endtask

  task automatic burst_chk(input logic [7:0] a, input int n, input int lat, input bit ss);
    start_rd(a, 1'b0, ss);
    repeat (lat - 1) tick();
    chk("R2 no word before latency", 32'(dvalid), 32'd0);
    chk("R5 indicator driven high in latency", {30'd0, eob_oe, eob_n}, 32'd3);
    tick();
    for (int k = 0; k < 2 * n; k++) begin
      logic [7:0] ea;
      ea = (a & ~8'(n - 1)) | ((a + 8'(k)) & 8'(n - 1));
      chk("R3 wrap order word", dq, wd(ea, ss));
      chk("R2 dvalid on word", 32'(dvalid), 32'd1);
      chk("R4 eob_n position", 32'(eob_n), (k % n == n - 1) ? 32'd0 : 32'd1);
      chk("R5 eob_oe driven", 32'(eob_oe), 32'd1);
      tick();
    end
  endtask

  task automatic t_reset_state();
    chk("R9 dq_oe in reset", 32'(dq_oe), 32'd0);
    chk("R9 eob_oe in reset", 32'(eob_oe), 32'd0);
    chk("R9 dvalid in reset", 32'(dvalid), 32'd0);
    rst_n = 1'b1; chip_en = 1'b1; out_en = 1'b1;
    tick();
    start_rd(8'h00, 1'b1, 1'b0);
    chk("R1 R10 default cfg readback", dq, 32'h16);
    chk("R10 reg read valid", 32'(dvalid), 32'd1);
  endtask

  task automatic t_bursts();
    set_cfg(6'h0B); burst_chk(8'h09, 2, 1, 1'b0);
    set_cfg(6'h15); burst_chk(8'h22, 4, 2, 1'b0);
    set_cfg(6'h0F); burst_chk(8'h45, 8, 1, 1'b0);
    start_rd(8'h00, 1'b1, 1'b0);
    chk("R1 cfg readback after write", dq, 32'h0F);
    set_cfg(6'h07); burst_chk(8'h80, 8, 1, 1'b0);
  endtask

  task automatic t_restart();
    set_cfg(6'h17);
    start_rd(8'h30, 1'b0, 1'b0);
    tick(); tick();
    chk("R6 first burst word", dq, wd(8'h30, 1'b0));
    tick();
    start_rd(8'h55, 1'b0, 1'b0);
    chk("R6 no word after restart", 32'(dvalid), 32'd0);
    tick();
    chk("R6 still in latency", 32'(dvalid), 32'd0);
    tick();
    chk("R6 new burst first word", dq, wd(8'h55, 1'b0));
    tick();
    chk("R6 new burst second word", dq, wd(8'h56, 1'b0));
  endtask

  task automatic t_ce_abort();
    set_cfg(6'h0D);
    start_rd(8'h10, 1'b0, 1'b0);
    tick();
    chk("R7 word before abort", dq, wd(8'h10, 1'b0));
    chip_en = 1'b0; #1;
    chk("R7 dq_oe released", 32'(dq_oe), 32'd0);
    chk("R7 eob_oe released", 32'(eob_oe), 32'd0);
    chk("R7 dvalid low", 32'(dvalid), 32'd0);
    tick();
    chip_en = 1'b1; #1;
    chk("R7 nothing after re-enable", {30'd0, dvalid, eob_oe}, 32'd0);
  endtask

  task automatic t_oe();
    set_cfg(6'h0D);
    start_rd(8'h10, 1'b0, 1'b0);
    tick();
    chk("R8 first word visible", dq, wd(8'h10, 1'b0));
    out_en = 1'b0; #1;
    chk("R8 bus released", {29'd0, dq_oe, eob_oe, dvalid}, 32'd0);
    tick(); tick(); tick();
    out_en = 1'b1; #1;
    chk("R8 sequence advanced while hidden", dq, wd(8'h13, 1'b0));
    chk("R8 last word flagged", 32'(eob_n), 32'd0);
    out_en = 1'b0;
    start_rd(8'h10, 1'b0, 1'b0);
    repeat (5) tick();
    out_en = 1'b1; #1;
    chk("R8 burst ended while hidden", {30'd0, dvalid, eob_oe}, 32'd0);
  endtask

  task automatic t_reset_mid();
    set_cfg(6'h0D);
    start_rd(8'h20, 1'b0, 1'b0);
    tick();
    chk("R9 burst running", 32'(dvalid), 32'd1);
    rst_n = 1'b0; #1;
    chk("R9 immediate release", {29'd0, dq_oe, eob_oe, dvalid}, 32'd0);
    tick();
    rst_n = 1'b1;
    tick();
    start_rd(8'h00, 1'b1, 1'b0);
    chk("R9 cfg restored", dq, 32'h16);
  endtask

  task automatic t_prot();
    start_rd(8'h01, 1'b1, 1'b0);
    chk("R10 protection word", dq, 32'h0000_00A5);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R10 held while out_en", dq, 32'h0000_00A5);
      chk("R10 no end flag", {30'd0, dvalid, eob_n}, 32'd3);
    end
  endtask

  task automatic t_single();
    set_cfg(6'h14);
    start_rd(8'h07, 1'b0, 1'b0);
    tick();
    chk("R11 latency respected", 32'(dvalid), 32'd0);
    tick();
    chk("R11 single word", dq, wd(8'h07, 1'b0));
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R11 word held", dq, wd(8'h07, 1'b0));
      chk("R11 no end flag", {30'd0, dvalid, eob_n}, 32'd3);
    end
  endtask

  task automatic t_secure();
    set_cfg(6'h0D);
    start_rd(8'h3E, 1'b0, 1'b1);
    tick();
    for (int k = 0; k < 4; k++) begin
      logic [7:0] ea;
      ea = 8'h3C | ((8'h3E + 8'(k)) & 8'h03);
      chk("R12 secured word", dq, wd(ea, 1'b1));
      chk("R12 secured word valid", 32'(data_bad), 32'd0);
      tick();
    end
    start_rd(8'h41, 1'b0, 1'b1);
    tick();
    chk("R12 out-of-window zeroed", dq, 32'd0);
    chk("R12 out-of-window flagged", {30'd0, dvalid, data_bad}, 32'd3);
  endtask

  initial begin
    #(CLK_P * 3);
    t_reset_state();
    t_bursts();
    t_restart();
    t_ce_abort();
    t_oe();
    t_reset_mid();
    t_prot();
    t_single();
    t_secure();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule